// File: doc/BRIEF.md
# Concatenated-Message Length-Extracting DMA Splitter

This block sits behind an OUT endpoint and turns a packetized byte stream into per-message buffer writes. The host may pack several variable-length messages back to back, so one packet can hold the tail of one message and the head of the next. Packets are at most 64 bytes, and a short packet appears only at the very end of the stream. Each message carries its own two-byte length at a configurable byte offset from the message's first byte. The block captures that length while the bytes stream past, even when the two length bytes fall in different packets. It then bounds the transfer by that length. Every byte goes to memory at the active descriptor's buffer address plus its position in the message.

Software loads a first descriptor through a load strobe. When a message's length is used up, the block retires the descriptor with a one-cycle strobe that reports status and the extracted length. If the descriptor's next-valid bit is set, the block takes the next descriptor from the chain port at that same clock edge and carries on with the remaining bytes of the packet without holding off the input. If the next-valid bit is clear and the message ends in the middle of a packet, the descriptor retires with an overrun status and the endpoint's DMA enable drops.

Top module: `concat_len_splitter`

## Requirements
- R1: After synchronous reset, every output is 0, including `in_ready`, `dma_enable`, both length flags, `dd_len`, `retire` and `retire_status`.
- R2: `dd_load` while `in_ready` is 0 starts a descriptor at `dd_addr`. On the next cycle `in_ready` and `dma_enable` are 1 and both length flags and `dd_len` are 0. `dd_load` while `in_ready` is 1 has no effect on later write addresses.
- R3: Byte j of a message, counted from 0, is written unchanged to `dd_addr` (or the chained `nx_addr`) plus j. `mem_we` is high in the cycle after the byte is accepted. The length bytes are written like any other byte.
- R4: The low length byte is the message byte at offset `cfg_len_ofs`, and the high byte is at `cfg_len_ofs`+1. `len_lo_done` rises in the cycle after the low byte. `len_hi_done` rises in the cycle after the high byte, and `dd_len` then equals {high, low}.
- R5: A packet boundary (`in_last`) between or before the length bytes does not reset the message byte position, and the length is still assembled correctly.
- R6: The descriptor retires on the byte whose 1-based position equals the extracted length, which counts the length field itself. `retire` is high for one cycle, together with that byte's write, and `retire_len` holds the extracted value.
- R7: If the extracted length is smaller than `cfg_len_ofs`+2, the descriptor retires on the high length byte.
- R8: On retirement, both flags and `dd_len` clear. With next-valid 1, the next byte goes to `nx_addr` and `in_ready` stays 1 with no idle cycle.
- R9: A retirement with next-valid 1, or on a byte marked `in_last`, reports `retire_status` 1 (normal). With next-valid 0, `in_ready` then drops and `dma_enable` stays 1.
- R10: A retirement with next-valid 0 on a byte not marked `in_last` reports `retire_status` 2 (overrun). It clears `dma_enable` and `in_ready`, and later input bytes are neither written nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_ofs | input | OFS_W | Byte offset of the low length byte within a message |
| dd_load | input | 1 | Start a descriptor when idle |
| dd_addr | input | ADDR_W | Buffer start address of the loaded descriptor |
| dd_next_valid | input | 1 | Next-valid bit of the loaded descriptor |
| nx_addr | input | ADDR_W | Buffer start address of the chained descriptor |
| nx_next_valid | input | 1 | Next-valid bit of the chained descriptor |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | A descriptor is active; bytes are accepted |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| dd_len | output | 16 | Buffer-length field of the active descriptor |
| len_lo_done | output | 1 | Low length byte captured |
| len_hi_done | output | 1 | High length byte captured |
| dma_enable | output | 1 | Endpoint DMA enable |
| retire | output | 1 | Descriptor retired this cycle |
| retire_status | output | 2 | 1 normal, 2 overrun, 0 when not retiring |
| retire_len | output | 16 | Extracted length of the retired descriptor |

## Verification
The hardest situation to reach is a length field split by a packet boundary inside a message that itself began mid-packet, followed at once by a chained descriptor switch within the same packet. The bench reaches it by sweeping every offset from 0 to 9 against packet sizes of 3 and 8, with three messages whose lengths shift with the offset. This lands the length bytes on every position relative to `in_last`, with and without idle bubbles. Directed cases add the overrun ending with stray trailing bytes, a length shorter than its own field, and a length with a non-zero high byte.

// File: rtl/spl_pkg.sv
package spl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        DD_NONE    = 2'd0,
        DD_NORMAL  = 2'd1,
        DD_OVERRUN = 2'd2
    } dd_status_e;

    typedef struct packed {
        logic              fire;
        dd_status_e        status;
        logic [LEN_W-1:0]  len;
    } retire_t;

    // Closing a descriptor is clean when a successor exists or the packet ends here.
    function automatic dd_status_e close_status(input logic next_valid, input logic pkt_end);
        return (next_valid || pkt_end) ? DD_NORMAL : DD_OVERRUN;
    endfunction

endpackage

// File: rtl/len_extract.sv
module len_extract
    import spl_pkg::*;
#(
    parameter int unsigned OFS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc,
    input  logic [BYTE_W-1:0] din,
    input  logic [OFS_W-1:0]  ofs,
    output logic [LEN_W:0]    cnt_inc,
    output logic              lo_f,
    output logic              hi_f,
    output logic              hi_now,
    output logic [LEN_W-1:0]  len_now,
    output logic [LEN_W-1:0]  len_q
);
    localparam int unsigned CW = LEN_W + 1;

    logic [LEN_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] lo_byte_q;
    logic              lo_q, hi_q;
    logic [CW-1:0]     cnt_x, ofs_x;
    logic              lo_now;

    assign cnt_x   = CW'(cnt_q);
    assign ofs_x   = CW'(ofs);
    assign cnt_inc = cnt_x + CW'(1);

    // Position counter runs across packet boundaries; only a new descriptor resets it.
    assign lo_now  = acc && !lo_q && (cnt_x == ofs_x);
    assign hi_now  = acc && lo_q && !hi_q && (cnt_x == ofs_x + CW'(1));
    assign len_now = {din, lo_byte_q};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q     <= '0;
            lo_byte_q <= '0;
            lo_q      <= 1'b0;
            hi_q      <= 1'b0;
            len_q     <= '0;
        end else if (acc) begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (lo_now) begin
                lo_byte_q <= din;
                lo_q      <= 1'b1;
            end
            if (hi_now) begin
                len_q <= len_now;
                hi_q  <= 1'b1;
            end
        end
    end

    assign lo_f = lo_q;
    assign hi_f = hi_q;

    p_hi_needs_lo_r4: assert property (@(posedge clk) disable iff (rst)
        hi_q |-> lo_q)
        else $error("high length flag without low flag");

    p_lo_at_offset_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> (cnt_x == ofs_x + CW'(1)))
        else $error("low length byte taken at wrong position");

    p_cnt_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!acc && !clr) |=> $stable(cnt_q))
        else $error("position counter moved without a byte");

endmodule

// File: rtl/desc_ctrl.sv
module desc_ctrl
    import spl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dd_load,
    input  logic [ADDR_W-1:0] dd_addr,
    input  logic              dd_nv,
    input  logic [ADDR_W-1:0] nx_addr,
    input  logic              nx_nv,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [LEN_W:0]    cnt_inc,
    input  logic              hi_f,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              hi_now,
    input  logic [LEN_W-1:0]  len_now,
    output logic              active,
    output logic              dma_en,
    output logic              acc,
    output logic              clr,
    output logic [ADDR_W-1:0] cur_addr,
    output retire_t           ret
);
    localparam int unsigned CW = LEN_W + 1;

    logic              active_q, dma_en_q, nv_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load, reach_old, reach_new, done;
    dd_status_e        st_now;
    logic [LEN_W-1:0]  done_len;

    assign load      = dd_load && !active_q;
    assign acc       = in_valid && active_q;
    assign reach_old = hi_f && (cnt_inc >= CW'(len_q));
    assign reach_new = hi_now && (CW'(len_now) <= cnt_inc);
    assign done      = acc && (reach_old || reach_new);
    assign done_len  = hi_now ? len_now : len_q;
    assign st_now    = close_status(nv_q, in_last);
    assign clr       = done || load;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dma_en_q <= 1'b0;
            nv_q     <= 1'b0;
            addr_q   <= '0;
            ret      <= '{fire: 1'b0, status: DD_NONE, len: '0};
        end else begin
            ret <= '{fire: done, status: done ? st_now : DD_NONE, len: done ? done_len : '0};
            if (load) begin
                active_q <= 1'b1;
                dma_en_q <= 1'b1;
                nv_q     <= dd_nv;
                addr_q   <= dd_addr;
            end else if (done) begin
                if (nv_q) begin
                    addr_q <= nx_addr;
                    nv_q   <= nx_nv;
                end else begin
                    active_q <= 1'b0;
                    if (st_now == DD_OVERRUN) dma_en_q <= 1'b0;
                end
            end else if (acc) begin
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    assign active   = active_q;
    assign dma_en   = dma_en_q;
    assign cur_addr = addr_q;

    p_overrun_stops_r10: assert property (@(posedge clk) disable iff (rst)
        (ret.fire && ret.status == DD_OVERRUN) |-> (!dma_en_q && !active_q))
        else $error("overrun retirement left the endpoint running");

    p_en_falls_on_overrun_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_en_q) |-> (ret.fire && ret.status == DD_OVERRUN))
        else $error("DMA enable dropped without an overrun");

    p_status_on_fire_r6: assert property (@(posedge clk) disable iff (rst)
        ret.fire |-> (ret.status != DD_NONE))
        else $error("retirement without a status");

    p_chain_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (done && nv_q) |=> active_q)
        else $error("chained descriptor dropped the input");

endmodule

// File: rtl/wr_port.sv
module wr_port
    import spl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              we,
    output logic [ADDR_W-1:0] wa,
    output logic [BYTE_W-1:0] wd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we <= 1'b0;
            wa <= '0;
            wd <= '0;
        end else begin
            we <= acc;
            wa <= acc ? addr : '0;
            wd <= acc ? din : '0;
        end
    end
endmodule

// File: rtl/concat_len_splitter.sv
module concat_len_splitter
    import spl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  cfg_len_ofs,
    input  logic              dd_load,
    input  logic [ADDR_W-1:0] dd_addr,
    input  logic              dd_next_valid,
    input  logic [ADDR_W-1:0] nx_addr,
    input  logic              nx_next_valid,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [15:0]       dd_len,
    output logic              len_lo_done,
    output logic              len_hi_done,
    output logic              dma_enable,
    output logic              retire,
    output logic [1:0]        retire_status,
    output logic [15:0]       retire_len
);
    logic              acc, clr, hi_f, hi_now, active;
    logic [LEN_W:0]    cnt_inc;
    logic [LEN_W-1:0]  len_q, len_now;
    logic [ADDR_W-1:0] cur_addr;
    retire_t           ret;

    len_extract #(.OFS_W(OFS_W)) u_len (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .acc     (acc),
        .din     (in_data),
        .ofs     (cfg_len_ofs),
        .cnt_inc (cnt_inc),
        .lo_f    (len_lo_done),
        .hi_f    (hi_f),
        .hi_now  (hi_now),
        .len_now (len_now),
        .len_q   (len_q)
    );

    desc_ctrl #(.ADDR_W(ADDR_W)) u_desc (
        .clk      (clk),
        .rst      (rst),
        .dd_load  (dd_load),
        .dd_addr  (dd_addr),
        .dd_nv    (dd_next_valid),
        .nx_addr  (nx_addr),
        .nx_nv    (nx_next_valid),
        .in_valid (in_valid),
        .in_last  (in_last),
        .cnt_inc  (cnt_inc),
        .hi_f     (hi_f),
        .len_q    (len_q),
        .hi_now   (hi_now),
        .len_now  (len_now),
        .active   (active),
        .dma_en   (dma_enable),
        .acc      (acc),
        .clr      (clr),
        .cur_addr (cur_addr),
        .ret      (ret)
    );

    wr_port #(.ADDR_W(ADDR_W)) u_wr (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .addr (cur_addr),
        .din  (in_data),
        .we   (mem_we),
        .wa   (mem_addr),
        .wd   (mem_wdata)
    );

    assign in_ready      = active;
    assign len_hi_done   = hi_f;
    assign dd_len        = len_q;
    assign retire        = ret.fire;
    assign retire_status = ret.status;
    assign retire_len    = ret.len;

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we) && !$past(retire)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)))
        else $error("write address did not advance by one");

    p_retire_with_write_r6: assert property (@(posedge clk) disable iff (rst)
        retire |-> mem_we)
        else $error("retirement without the final write");

endmodule

// File: tb/concat_len_splitter_tb.sv
module concat_len_splitter_tb;
    localparam int ADDR_W = 16;
    localparam int OFS_W  = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic [OFS_W-1:0]  cfg_len_ofs;
    logic              dd_load, dd_next_valid, nx_next_valid;
    logic [ADDR_W-1:0] dd_addr, nx_addr;
    logic              in_valid, in_last;
    logic [7:0]        in_data;
    logic              in_ready, mem_we, len_lo_done, len_hi_done, dma_enable, retire;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [15:0]       dd_len, retire_len;
    logic [1:0]        retire_status;

    concat_len_splitter #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_len_ofs(cfg_len_ofs),
        .dd_load(dd_load), .dd_addr(dd_addr), .dd_next_valid(dd_next_valid),
        .nx_addr(nx_addr), .nx_next_valid(nx_next_valid),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dd_len(dd_len), .len_lo_done(len_lo_done), .len_hi_done(len_hi_done),
        .dma_enable(dma_enable), .retire(retire), .retire_status(retire_status),
        .retire_len(retire_len)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_a [0:1023];
    int exp_d [0:1023];
    int n_exp = 0, wp = 0;
    int r_len [0:7];
    int r_st  [0:7];
    int n_ret = 0, rp = 0;
    int lens  [0:3];
    string tag = "R1";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int base_of(input int m);
        return 'h0400 * (m + 1) + 'h10;
    endfunction

    // Write and retire monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wp < n_exp) begin
                    chk({tag, " R3 write address"}, int'(mem_addr), exp_a[wp]);
                    chk({tag, " R3 write data"}, int'(mem_wdata), exp_d[wp]);
                end else begin
                    chk({tag, " R10 stray write"}, 1, 0);
                end
                wp++;
            end
            if (retire) begin
                if (rp < n_ret) begin
                    chk({tag, " R6 retire length"}, int'(retire_len), r_len[rp]);
                    chk({tag, " R9/R10 retire status"}, int'(retire_status), r_st[rp]);
                end else begin
                    chk({tag, " R6 extra retire"}, 1, 0);
                end
                rp++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_case(input int off, input int pk, input int nmsg, input int junk,
                            input bit bub, input bit glitch, input bit exp_en, input string tg);
        int sb [0:511];
        int sm [0:511];
        int sj [0:511];
        int plen [0:3];
        int tot = 0;
        tag = tg;
        n_exp = 0; n_ret = 0; wp = 0; rp = 0;
        for (int m = 0; m < nmsg; m++) begin
            plen[m] = (lens[m] < off + 2) ? off + 2 : lens[m];
            for (int j = 0; j < plen[m]; j++) begin
                int v;
                if (j == off)          v = lens[m] & 255;
                else if (j == off + 1) v = (lens[m] >> 8) & 255;
                else                   v = (m * 37 + j * 5 + off + 1) & 255;
                sb[tot] = v; sm[tot] = m; sj[tot] = j;
                exp_a[n_exp] = base_of(m) + j;
                exp_d[n_exp] = v;
                n_exp++; tot++;
            end
        end
        for (int k = 0; k < junk; k++) begin
            sb[tot] = 'hA5; sm[tot] = -1; sj[tot] = 0; tot++;
        end
        for (int m = 0; m < nmsg; m++) begin
            r_len[m] = lens[m];
            r_st[m]  = 1;
        end
        // last message ends mid-packet when its final byte is not a packet end
        if ((n_exp - 1) % pk != pk - 1 && n_exp != tot) r_st[nmsg-1] = 2;
        n_ret = nmsg;

        cfg_len_ofs   = OFS_W'(off);
        dd_load       = 1'b1;
        dd_addr       = ADDR_W'(base_of(0));
        dd_next_valid = (nmsg > 1);
        @(negedge clk);
        dd_load = 1'b0;
        chk({tg, " R2 ready after load"}, int'(in_ready), 1);
        chk({tg, " R2 enable after load"}, int'(dma_enable), 1);
        chk({tg, " R2 flags after load"}, int'({len_lo_done, len_hi_done}), 0);
        chk({tg, " R2 length after load"}, int'(dd_len), 0);

        for (int k = 0; k < tot; k++) begin
            int m;
            m = sm[k];
            if (bub && (k % 5 == 2)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            if (m >= 0) chk({tg, " R8 ready before byte"}, int'(in_ready), 1);
            in_valid = 1'b1;
            in_data  = 8'(sb[k]);
            in_last  = (k % pk == pk - 1) || (k == tot - 1);
            if (m >= 0) begin
                nx_addr       = ADDR_W'(base_of(m + 1));
                nx_next_valid = (m + 1 < nmsg - 1);
            end
            dd_load       = glitch && (k == 3);
            dd_addr       = 16'hF000;
            dd_next_valid = 1'b0;
            @(negedge clk);
            dd_load = 1'b0;
            if (m < 0) begin
                chk({tg, " R10 flags idle"}, int'({len_lo_done, len_hi_done}), 0);
                chk({tg, " R10 ready idle"}, int'(in_ready), 0);
            end else if (sj[k] == plen[m] - 1) begin
                chk({tg, " R8 flags cleared"}, int'({len_lo_done, len_hi_done}), 0);
                chk({tg, " R8 length cleared"}, int'(dd_len), 0);
                chk({tg, " R8 ready after retire"}, int'(in_ready), (m != nmsg - 1) ? 1 : 0);
            end else begin
                int j;
                j = sj[k];
                chk({tg, " R4/R5 low flag"}, int'(len_lo_done), (j >= off) ? 1 : 0);
                chk({tg, " R4/R5 high flag"}, int'(len_hi_done), (j >= off + 1) ? 1 : 0);
                chk({tg, " R4/R5 length field"}, int'(dd_len), (j >= off + 1) ? lens[m] : 0);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (3) @(negedge clk);
        chk({tg, " R3 write count"}, wp, n_exp);
        chk({tg, " R6 retire count"}, rp, n_ret);
        chk({tg, " R9/R10 enable at end"}, int'(dma_enable), exp_en ? 1 : 0);
        chk({tg, " R9/R10 ready at end"}, int'(in_ready), 0);
    endtask

    initial begin
        rst = 1'b1;
        cfg_len_ofs = '0; dd_load = 1'b0; dd_addr = '0; dd_next_valid = 1'b0;
        nx_addr = '0; nx_next_valid = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset writes", int'(mem_we), 0);
        chk("R1 reset ready/enable", int'({in_ready, dma_enable}), 0);
        chk("R1 reset flags", int'({len_lo_done, len_hi_done}), 0);
        chk("R1 reset length", int'(dd_len), 0);
        chk("R1 reset retire", int'({retire, retire_status}), 0);
        chk("R1 reset retire length", int'(retire_len), 0);

        // Sweep offsets over two packet sizes so the length field lands everywhere
        foreach (lens[i]) lens[i] = 0;
        for (int pk = 3; pk <= 8; pk += 5) begin
            for (int off = 0; off < 10; off++) begin
                lens[0] = off + 7;
                lens[1] = off + 15;
                lens[2] = off + 2;
                run_case(off, pk, 3, 0, (off % 2) == 1, off == 1, 1'b1,
                         (off == 1) ? "R2 sweep" : "R5 sweep");
            end
        end

        // R7: length smaller than its own field end
        lens[0] = 1; lens[1] = 9; lens[2] = 0;
        run_case(2, 8, 3, 0, 1'b0, 1'b0, 1'b1, "R7 short");

        // 160 + 100 byte messages in 64-byte packets
        lens[0] = 160; lens[1] = 100;
        run_case(0, 64, 2, 0, 1'b0, 1'b0, 1'b1, "R5 packed");

        // Non-zero high length byte
        lens[0] = 300; lens[1] = 20;
        run_case(3, 64, 2, 0, 1'b1, 1'b0, 1'b1, "R4 wide");

        // R10: ends mid-packet with no successor; trailing bytes ignored
        lens[0] = 5;
        run_case(1, 8, 1, 3, 1'b0, 1'b0, 1'b0, "R10 overrun");

        // R9: restart after overrun, end on a short packet
        lens[0] = 6;
        run_case(0, 8, 1, 0, 1'b0, 1'b0, 1'b1, "R9 clean end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule